// File: doc/BRIEF.md
# DMA Global Run Control

This unit sits beside the channels of a multi-channel DMA engine and decides, for every channel on every cycle, whether that channel may move data. It keeps one global enable bit and two sticky fault indicators in a single software-visible control word. One indicator latches address faults reported by the channels. The other latches non-maskable interrupt events. Each channel supplies its own enable bit, its transfer-end bit, a busy indication and a pulse that marks the end of one transfer unit. The unit returns a registered permit bit for each channel.

The two fault indicators stop the channels in different ways. An address fault removes every permit on the next cycle. A non-maskable interrupt lets a channel that is already running finish its current transfer unit, and only then withdraws its permit. Clearing either indicator takes a deliberate two-step sequence. Software must first read the word and see the indicator at 1. The next write must then carry a 0 in that bit position. When the global enable falls, the unit sends a one-cycle halt pulse to the channels, and every permit drops in the same cycle as that pulse.

Top module: `dma_master_ctl`

## Requirements
- R1: After synchronous reset, `run_permit` and `halt_req` are 0, and a read returns 0.
- R2: A read strobe captures the control word into `reg_rdata`, which is valid in the cycle after the strobe. The global enable is at bit 0, the interrupt indicator at bit 1 and the address-fault indicator at bit 2. All higher bits read as 0.
- R3: Every write loads bit 0 of `reg_wdata` into the global enable.
- R4: Outside any fault condition, `run_permit[i]` equals the global enable AND `ch_enable[i]` AND NOT `ch_tend[i]`, evaluated on the previous cycle's state.
- R5: A cycle with `nmi_in` high sets the interrupt indicator, even when no channel is running. A cycle with `addr_err_in` high sets the address-fault indicator.
- R6: While either indicator is 1, no channel gains a permit it did not already hold.
- R7: An indicator is cleared only by a write with 0 in its bit, and only when the most recent register access before that write was a read that returned 1 in that bit. Any write consumes that arming. A write with 1 in an indicator bit never changes the indicator.
- R8: If a set event and a valid clearing write occur in the same cycle, the indicator stays 1.
- R9: After the interrupt indicator rises, a channel that holds a permit and is busy keeps it until its `ch_unit_done` pulse, and loses it on the next cycle. Every other channel loses its permit.
- R10: Once the address-fault indicator is 1, all permits are 0 from the next cycle on, whether or not the channels are busy.
- R11: When the global enable falls, `halt_req` is high for exactly one cycle, and all permits are 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_rd | input | 1 | Read strobe for the control word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| nmi_in | input | 1 | Non-maskable interrupt event |
| addr_err_in | input | 1 | Address fault reported by a channel |
| ch_enable | input | NUM_CH | Per-channel enable bits |
| ch_tend | input | NUM_CH | Per-channel transfer-end bits |
| ch_busy | input | NUM_CH | Channel is inside a transfer unit |
| ch_unit_done | input | NUM_CH | Pulse marking the end of a transfer unit |
| run_permit | output | NUM_CH | Per-channel run permission |
| halt_req | output | 1 | One-cycle pulse when the global enable falls |

## Verification
The following properties are checked on every cycle:
- Each indicator is set on the cycle after its event.
- An indicator falls only after a write that carried 0 in its bit, with no event in the same cycle.
- No permit appears without the global enable and the channel enable.
- An address fault empties the permits on the next cycle.
- No new permit appears under an interrupt.
- A falling enable produces a single halt pulse together with empty permits.

Some behaviour can only be shown by the bench's scenarios. The exact permit pattern over all enable and transfer-end combinations is one. The others are:
- the read-then-write clearing handshake, including writes that are not armed and writes of 1;
- a busy channel draining until its unit-done pulse;
- an interrupt taken while the engine is idle.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  // Bit positions in the control word; software decodes these.
  localparam int ME_BIT  = 0;
  localparam int NMI_BIT = 1;
  localparam int AE_BIT  = 2;
  localparam int USED_BITS = 3;
endpackage

// File: rtl/dmac_status_reg.sv
module dmac_status_reg
  import dmac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              nmi_in,
  input  logic              addr_err_in,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              master_en,
  output logic              nmi_flag,
  output logic              ae_flag,
  output logic              halt_req
);
  logic              nmi_arm;
  logic              ae_arm;
  logic              me_del;
  logic [DATA_W-1:0] status_word;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:USED_BITS];

  always_comb begin
    status_word          = '0;
    status_word[ME_BIT]  = master_en;
    status_word[NMI_BIT] = nmi_flag;
    status_word[AE_BIT]  = ae_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master_en <= 1'b0;
      nmi_flag  <= 1'b0;
      ae_flag   <= 1'b0;
      nmi_arm   <= 1'b0;
      ae_arm    <= 1'b0;
      me_del    <= 1'b0;
      halt_req  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) master_en <= reg_wdata[ME_BIT];

      // A set event outranks a clearing write.
      if (nmi_in)
        nmi_flag <= 1'b1;
      else if (reg_wr && nmi_arm && !reg_wdata[NMI_BIT])
        nmi_flag <= 1'b0;

      if (addr_err_in)
        ae_flag <= 1'b1;
      else if (reg_wr && ae_arm && !reg_wdata[AE_BIT])
        ae_flag <= 1'b0;

      // Arming comes from a read that saw 1; any write consumes it.
      if (reg_wr)
        nmi_arm <= 1'b0;
      else if (reg_rd && nmi_flag)
        nmi_arm <= 1'b1;

      if (reg_wr)
        ae_arm <= 1'b0;
      else if (reg_rd && ae_flag)
        ae_arm <= 1'b1;

      if (reg_rd) reg_rdata <= status_word;

      me_del   <= master_en;
      halt_req <= me_del & ~master_en;
    end
  end
endmodule

// File: rtl/dmac_permit_gen.sv
module dmac_permit_gen #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_en,
  input  logic              nmi_flag,
  input  logic              ae_flag,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [NUM_CH-1:0] ch_tend,
  input  logic [NUM_CH-1:0] ch_busy,
  input  logic [NUM_CH-1:0] ch_unit_done,
  output logic [NUM_CH-1:0] run_permit
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic permit_q;
    logic base_ok;
    logic drain_ok;

    assign base_ok  = master_en & ch_enable[i] & ~ch_tend[i] & ~ae_flag;
    // Under an interrupt, a running busy channel finishes its current unit.
    assign drain_ok = permit_q & ch_busy[i] & ~ch_unit_done[i];

    always_ff @(posedge clk) begin
      if (rst) permit_q <= 1'b0;
      else     permit_q <= base_ok & (~nmi_flag | drain_ok);
    end

    assign run_permit[i] = permit_q;
  end
endmodule

// File: rtl/dma_master_ctl.sv
module dma_master_ctl #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              nmi_in,
  input  logic              addr_err_in,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [NUM_CH-1:0] ch_tend,
  input  logic [NUM_CH-1:0] ch_busy,
  input  logic [NUM_CH-1:0] ch_unit_done,
  output logic [NUM_CH-1:0] run_permit,
  output logic              halt_req
);
  logic master_en;
  logic nmi_flag;
  logic ae_flag;

  dmac_status_reg #(.DATA_W(DATA_W)) u_status (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .nmi_in      (nmi_in),
    .addr_err_in (addr_err_in),
    .reg_rdata   (reg_rdata),
    .master_en   (master_en),
    .nmi_flag    (nmi_flag),
    .ae_flag     (ae_flag),
    .halt_req    (halt_req)
  );

  dmac_permit_gen #(.NUM_CH(NUM_CH)) u_permit (
    .clk          (clk),
    .rst          (rst),
    .master_en    (master_en),
    .nmi_flag     (nmi_flag),
    .ae_flag      (ae_flag),
    .ch_enable    (ch_enable),
    .ch_tend      (ch_tend),
    .ch_busy      (ch_busy),
    .ch_unit_done (ch_unit_done),
    .run_permit   (run_permit)
  );
endmodule

// File: rtl/dma_master_ctl_chk.sv
module dma_master_ctl_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              nmi_in,
  input logic              addr_err_in,
  input logic              master_en,
  input logic              nmi_flag,
  input logic              ae_flag,
  input logic [NUM_CH-1:0] ch_enable,
  input logic [NUM_CH-1:0] run_permit,
  input logic              halt_req
);
  assert_nmi_sets_R5: assert property (@(posedge clk) disable iff (rst)
    nmi_in |=> nmi_flag);

  assert_ae_sets_R5: assert property (@(posedge clk) disable iff (rst)
    addr_err_in |=> ae_flag);

  assert_nmi_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_flag) |-> ($past(reg_wr) && !$past(reg_wdata[1]) && !$past(nmi_in)));

  assert_ae_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(ae_flag) |-> ($past(reg_wr) && !$past(reg_wdata[2]) && !$past(addr_err_in)));

  assert_permit_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    (|run_permit) |-> ($past(master_en) && ((run_permit & ~$past(ch_enable)) == '0)));

  assert_no_new_permit_R6: assert property (@(posedge clk) disable iff (rst)
    nmi_flag |=> ((run_permit & ~$past(run_permit)) == '0));

  assert_ae_stops_R10: assert property (@(posedge clk) disable iff (rst)
    ae_flag |=> (run_permit == '0));

  assert_halt_on_fall_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(master_en) |=> (halt_req && (run_permit == '0)));

  assert_halt_single_R11: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !halt_req);
endmodule

bind dma_master_ctl dma_master_ctl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .nmi_in      (nmi_in),
  .addr_err_in (addr_err_in),
  .master_en   (master_en),
  .nmi_flag    (nmi_flag),
  .ae_flag     (ae_flag),
  .ch_enable   (ch_enable),
  .run_permit  (run_permit),
  .halt_req    (halt_req)
);

// File: tb/sim_dma_master_ctl.sv
`timescale 1ns/1ps
module sim_dma_master_ctl;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              nmi_in = 1'b0;
  logic              addr_err_in = 1'b0;
  logic [NUM_CH-1:0] ch_enable = '0;
  logic [NUM_CH-1:0] ch_tend = '0;
  logic [NUM_CH-1:0] ch_busy = '0;
  logic [NUM_CH-1:0] ch_unit_done = '0;
  logic [NUM_CH-1:0] run_permit;
  logic              halt_req;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DATA_W-1:0] rd_val;

  always #2 clk = ~clk;

  dma_master_ctl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_in(nmi_in),
    .addr_err_in(addr_err_in), .ch_enable(ch_enable), .ch_tend(ch_tend),
    .ch_busy(ch_busy), .ch_unit_done(ch_unit_done),
    .run_permit(run_permit), .halt_req(halt_req)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [DATA_W-1:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(output logic [DATA_W-1:0] d);
    reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 permit", 32'(run_permit), 32'h0);
    check("R1 halt", 32'(halt_req), 32'h0);
    reg_read(rd_val);
    check("R1 read", rd_val, 32'h0);

    // R2 / R3: upper write bits ignored, enable from bit 0
    reg_write(32'hFFFF_FFF9);
    reg_read(rd_val);
    check("R2 R3 word", rd_val, 32'h1);
    reg_write(32'h0);
    reg_read(rd_val);
    check("R3 enable off", rd_val, 32'h0);

    // R4 sweep with enable off then on
    for (int me = 0; me < 2; me++) begin
      reg_write(DATA_W'(me));
      for (int en = 0; en < 16; en++) begin
        for (int te = 0; te < 16; te++) begin
          ch_enable = NUM_CH'(en); ch_tend = NUM_CH'(te);
          tick();
          check("R4 permit", 32'(run_permit), (me == 1) ? 32'(en & ~te & 4'hF) : 32'h0);
        end
      end
    end

    // R9 interrupt drain: channel 0 busy, the rest idle
    ch_enable = 4'hF; ch_tend = 4'h0; ch_busy = 4'b0001;
    tick();
    check("R4 all on", 32'(run_permit), 32'hF);
    nmi_in = 1'b1; tick(); nmi_in = 1'b0;
    tick();
    check("R9 drain start", 32'(run_permit), 32'h1);
    tick();
    check("R9 drain hold", 32'(run_permit), 32'h1);
    ch_unit_done = 4'b0001; tick(); ch_unit_done = 4'h0;
    check("R9 unit done", 32'(run_permit), 32'h0);
    ch_busy = 4'h0;
    tick();
    check("R6 no restart", 32'(run_permit), 32'h0);

    // R5 / R8 / R7 clearing handshake
    reg_read(rd_val);
    check("R5 nmi flag", rd_val, 32'h3);
    reg_wr = 1'b1; reg_wdata = 32'h1; nmi_in = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; nmi_in = 1'b0;
    reg_read(rd_val);
    check("R8 set wins", rd_val, 32'h3);
    reg_write(32'h3);
    reg_read(rd_val);
    check("R7 write one", rd_val, 32'h3);
    reg_write(32'h3);
    reg_write(32'h1);
    reg_read(rd_val);
    check("R7 unarmed write", rd_val, 32'h3);
    reg_write(32'h1);
    reg_read(rd_val);
    check("R7 cleared", rd_val, 32'h1);
    check("R4 resume", 32'(run_permit), 32'hF);

    // R5 interrupt while idle
    reg_write(32'h0);
    ch_enable = 4'h0;
    nmi_in = 1'b1; tick(); nmi_in = 1'b0;
    reg_read(rd_val);
    check("R5 idle nmi", rd_val, 32'h2);
    reg_write(32'h0);
    reg_read(rd_val);
    check("R7 idle clear", rd_val, 32'h0);

    // R10 address fault stops busy channels at once
    reg_write(32'h1);
    ch_enable = 4'hF; ch_busy = 4'hF;
    tick(); tick();
    check("R4 busy on", 32'(run_permit), 32'hF);
    addr_err_in = 1'b1; tick(); addr_err_in = 1'b0;
    tick();
    check("R10 stop", 32'(run_permit), 32'h0);
    reg_read(rd_val);
    check("R5 ae flag", rd_val, 32'h5);
    reg_write(32'h1);
    reg_read(rd_val);
    check("R7 ae clear", rd_val, 32'h1);
    check("R4 after ae", 32'(run_permit), 32'hF);

    // R11 halt pulse
    tick();
    reg_write(32'h0);
    check("R11 before", 32'(halt_req), 32'h0);
    tick();
    check("R11 pulse", 32'(halt_req), 32'h1);
    check("R11 permit", 32'(run_permit), 32'h0);
    tick();
    check("R11 single", 32'(halt_req), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule